// File: doc/BRIEF.md
# Two-wire bus condition detector

This block sits between the two raw lines of a two-wire serial bus (clock and data) and the protocol logic of a slave. Both lines are sampled by a fast system clock, brought through a synchronizer chain, and cleaned by a digital filter. A filtered line takes a new level only once that level has been seen for `FILT_LEN` consecutive system clocks, so short spikes on either line are dropped and cause no event.

The filtered lines are then decoded into one-cycle strobes. A start condition is the data line falling while the clock line is high. A stop condition is the data line rising while the clock line is high. The decoder also gives separate strobes for the clock rising and the clock falling. A data change while the clock is low is ordinary data and yields no strobe. When a start or stop is seen in the same cycle as a clock edge, the condition strobe wins and the edge strobe is withheld. A bus-idle flag tracks whether a transfer is open.

For the transmit direction, the slave presents the data value it wants to drive as a pull-low request. The block passes that request to the open-drain enable only after the filtered clock has been low for `HOLD_LEN` system clocks. This keeps the slave from moving the data line near a clock edge, where the move would look like a false start or stop.

Top module: `twb_cond_detect`

## Requirements
- R1: `start_stb` is high for exactly one cycle when the filtered data line falls while the filtered clock line is high. With the default parameters it appears SYNC_STAGES+FILT_LEN+1 = 6 clocks after the raw change is first sampled.
- R2: `stop_stb` is high for exactly one cycle when the filtered data line rises while the filtered clock line is high.
- R3: `scl_rise_stb` and `scl_fall_stb` are each high for one cycle per filtered clock edge. A data change while the clock is low raises no strobe at all.
- R4: A level on either line that is held for fewer than `FILT_LEN` consecutive samples produces no strobe. A level held for exactly `FILT_LEN` samples is accepted.
- R5: `bus_idle` is 1 after reset and after a stop condition when both lines are high. It is 0 from the cycle of a start condition onward, and 0 while either filtered line is low.
- R6: A start or stop in the same cycle as a clock edge suppresses that edge strobe. Clock rising together with data falling gives only `start_stb`. Clock rising together with data rising gives only `stop_stb`.
- R7: `sda_oe` (1 = pull data low) copies `tx_pull_low` only while the filtered clock is low and has been low for at least `HOLD_LEN` clocks. It changes exactly `HOLD_LEN` cycles after `scl_fall_stb` asserts, it follows a request made inside an open window one cycle later, and it ignores requests made while the clock is high.
- R8: While `rst` is high and right after it falls, all strobes are 0, `bus_idle` is 1 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| tx_pull_low | input | 1 | Slave request to drive data low (1 = low) |
| sda_oe | output | 1 | Open-drain enable for the data line, applied after the hold delay |
| start_stb | output | 1 | One-cycle start condition strobe |
| stop_stb | output | 1 | One-cycle stop condition strobe |
| scl_rise_stb | output | 1 | One-cycle filtered clock rising strobe |
| scl_fall_stb | output | 1 | One-cycle filtered clock falling strobe |
| bus_idle | output | 1 | No transfer open and both lines high |

## Verification
Each stimulus step moves the two lines through a short first level and then a settled second level, and counts every strobe type in the window. The steps used are:
- clean starts and stops;
- clock edges with the data line steady;
- data changes while the clock is low;
- sub-threshold spikes on each line, and a pulse exactly `FILT_LEN` long.

These separate a condition from data, and a spike from a real level. Steps that move both lines in the same cycle check the priority rule, because a decoder that keeps the edge strobe would show an extra count there.

Directed tests measure the following:
- the latency from a raw change to its strobe;
- the exact cycle distance from the falling-clock strobe to the change of the output enable;
- that requests made while the clock is high are held off.

Together these distinguish a correctly timed hold gate from one that is early, late or transparent.

// File: rtl/twb_pkg.sv
package twb_pkg;

  // One set of decoded bus events, registered together.
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } twb_evt_t;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/twb_sync.sv
// Multi-stage synchronizer; resets to the bus idle level (high).
module twb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[g] <= 1'b1;
        end else begin
          if (g == 0) begin
            chain[g] <= d_in;
          end else begin
            chain[g] <= chain[(g == 0) ? 0 : g-1];
          end
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/twb_glitch_filter.sv
// Accepts a new level only after it has differed from the held level
// for LEN consecutive clocks.
module twb_glitch_filter #(
  parameter int unsigned LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_cnt;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      run_cnt <= '0;
    end else if (d_in == level_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level_q <= d_in;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign d_out = level_q;

endmodule

// File: rtl/twb_event_decode.sv
// Turns filtered line levels into registered one-cycle strobes.
module twb_event_decode
  import twb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_f,
  input  logic     sda_f,
  output twb_evt_t evt,
  output logic     idle
);

  logic scl_p, sda_p;
  logic busy_q, busy_d;
  logic c_start, c_stop, c_rise, c_fall;

  always_comb begin
    c_start = sda_p & ~sda_f & scl_f;
    c_stop  = ~sda_p & sda_f & scl_f;
    // A bus condition outranks a clock edge in the same cycle.
    c_rise  = ~scl_p & scl_f & ~(c_start | c_stop);
    c_fall  = scl_p & ~scl_f & ~(c_start | c_stop);
    busy_d  = busy_q;
    if (c_start) begin
      busy_d = 1'b1;
    end else if (c_stop) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
      evt    <= '0;
      idle   <= 1'b1;
    end else begin
      scl_p     <= scl_f;
      sda_p     <= sda_f;
      busy_q    <= busy_d;
      evt.start <= c_start;
      evt.stop  <= c_stop;
      evt.rise  <= c_rise;
      evt.fall  <= c_fall;
      idle      <= ~busy_d & scl_f & sda_f;
    end
  end

endmodule

// File: rtl/twb_hold_gate.sv
// Lets the slave's pull-low request reach the pad enable only once the
// filtered clock has been low for HOLD clocks.
module twb_hold_gate #(
  parameter int unsigned HOLD = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic req,
  output logic oe
);

  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD);

  logic [HW-1:0] low_cnt;
  logic          window;

  assign window = ~scl_f & (low_cnt == HMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      oe      <= 1'b0;
    end else begin
      if (scl_f) begin
        low_cnt <= '0;
      end else if (low_cnt != HMAX) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (window) begin
        oe <= req;
      end
    end
  end

endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
  import twb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned HOLD_LEN    = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tx_pull_low,
  output logic sda_oe,
  output logic start_stb,
  output logic stop_stb,
  output logic scl_rise_stb,
  output logic scl_fall_stb,
  output logic bus_idle
);

  logic [NUM_LINES-1:0] raw, synced, filt;
  logic scl_flt, sda_flt;
  twb_evt_t evt;

  assign raw[LINE_SCL] = scl_in;
  assign raw[LINE_SDA] = sda_in;

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      twb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(raw[l]), .d_out(synced[l])
      );
      twb_glitch_filter #(.LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .d_in(synced[l]), .d_out(filt[l])
      );
    end
  endgenerate

  assign scl_flt = filt[LINE_SCL];
  assign sda_flt = filt[LINE_SDA];

  twb_event_decode u_dec (
    .clk(clk), .rst(rst), .scl_f(scl_flt), .sda_f(sda_flt),
    .evt(evt), .idle(bus_idle)
  );

  twb_hold_gate #(.HOLD(HOLD_LEN)) u_hold (
    .clk(clk), .rst(rst), .scl_f(scl_flt), .req(tx_pull_low), .oe(sda_oe)
  );

  assign start_stb    = evt.start;
  assign stop_stb     = evt.stop;
  assign scl_rise_stb = evt.rise;
  assign scl_fall_stb = evt.fall;

endmodule

// File: rtl/twb_cond_detect_chk.sv
module twb_cond_detect_chk #(
  parameter int unsigned HOLD_LEN = 15
) (
  input logic clk,
  input logic rst,
  input logic scl_flt,
  input logic sda_oe,
  input logic start_stb,
  input logic stop_stb,
  input logic scl_rise_stb,
  input logic scl_fall_stb,
  input logic bus_idle
);

  localparam int unsigned RW = $clog2(HOLD_LEN + 2);
  localparam logic [RW-1:0] RMAX = RW'(HOLD_LEN + 1);

  // Independent count of consecutive low cycles of the filtered clock.
  logic [RW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
    end else if (scl_flt) begin
      low_run <= '0;
    end else if (low_run != RMAX) begin
      low_run <= low_run + 1'b1;
    end
  end

  assert_start_single_R1: assert property (@(posedge clk) disable iff (rst)
    start_stb |=> !start_stb);

  assert_stop_single_R2: assert property (@(posedge clk) disable iff (rst)
    stop_stb |=> !stop_stb);

  assert_edges_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise_stb && scl_fall_stb));

  assert_idle_start_R5: assert property (@(posedge clk) disable iff (rst)
    start_stb |-> !bus_idle);

  assert_idle_stop_R5: assert property (@(posedge clk) disable iff (rst)
    stop_stb |-> bus_idle);

  assert_cond_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (start_stb || stop_stb) |-> !(scl_rise_stb || scl_fall_stb));

  assert_oe_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(low_run) >= RW'(HOLD_LEN)));

endmodule

bind twb_cond_detect twb_cond_detect_chk #(.HOLD_LEN(HOLD_LEN)) u_chk (
  .clk(clk), .rst(rst), .scl_flt(scl_flt), .sda_oe(sda_oe),
  .start_stb(start_stb), .stop_stb(stop_stb),
  .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb),
  .bus_idle(bus_idle)
);

// File: tb/twb_cond_detect_tb.sv
module twb_cond_detect_tb;

  localparam int SYNC_STAGES = 2;
  localparam int FILT_LEN    = 3;
  localparam int HOLD_LEN    = 15;
  localparam int SETTLE      = 20;
  localparam int NVEC        = 10;

  typedef struct packed {
    logic       scl_a;
    logic       sda_a;
    logic [3:0] len_a;
    logic       scl_b;
    logic       sda_b;
    logic [1:0] e_start;
    logic [1:0] e_stop;
    logic [1:0] e_rise;
    logic [1:0] e_fall;
    logic       e_idle;
  } vec_t;

  // Level A for len_a clocks, then level B for SETTLE clocks; expected
  // strobe counts over the step and bus_idle at its end.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0}, // start
    '{1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0}, // clk fall
    '{1'b0, 1'b1, 4'd5, 1'b1, 1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0}, // data@low, rise
    '{1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // sda spike
    '{1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // scl spike
    '{1'b0, 1'b1, 4'd6, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0}, // fall, data@low
    '{1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 2'd0, 2'd1, 2'd1, 2'd0, 1'b1}, // rise, stop
    '{1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 2'd1, 2'd1, 2'd0, 2'd0, 1'b1}, // exact-length pulse
    '{1'b0, 1'b1, 4'd6, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 2'd1, 1'b0}, // rise+fall sda
    '{1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 2'd0, 2'd1, 2'd0, 2'd1, 1'b1}  // rise+rise sda
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic tx_pull_low = 1'b0;
  logic sda_oe, start_stb, stop_stb, scl_rise_stb, scl_fall_stb, bus_idle;

  int n_checks = 0;
  int n_fail   = 0;
  int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0;

  always #10 clk = ~clk;

  twb_cond_detect #(
    .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .HOLD_LEN(HOLD_LEN)
  ) u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .tx_pull_low(tx_pull_low), .sda_oe(sda_oe),
    .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb),
    .bus_idle(bus_idle)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (start_stb)    c_start++;
      if (stop_stb)     c_stop++;
      if (scl_rise_stb) c_rise++;
      if (scl_fall_stb) c_fall++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic d);
    scl_in = s;
    sda_in = d;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int s0, p0, r0, f0, k;
    wait_cyc(4);
    // R8: reset state
    check("R8", "idle in reset", int'(bus_idle), 1);
    check("R8", "oe in reset", int'(sda_oe), 0);
    check("R8", "strobes in reset",
          int'({start_stb, stop_stb, scl_rise_stb, scl_fall_stb}), 0);
    rst = 1'b0;
    wait_cyc(SETTLE);
    check("R8", "idle after reset", int'(bus_idle), 1);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      s0 = c_start; p0 = c_stop; r0 = c_rise; f0 = c_fall;
      drive(VEC[v].scl_a, VEC[v].sda_a);
      wait_cyc(int'(VEC[v].len_a));
      drive(VEC[v].scl_b, VEC[v].sda_b);
      wait_cyc(SETTLE);
      check("R1", $sformatf("vec%0d start count", v), c_start - s0, int'(VEC[v].e_start));
      check("R2", $sformatf("vec%0d stop count", v), c_stop - p0, int'(VEC[v].e_stop));
      check("R3", $sformatf("vec%0d rise count", v), c_rise - r0, int'(VEC[v].e_rise));
      check("R3", $sformatf("vec%0d fall count", v), c_fall - f0, int'(VEC[v].e_fall));
      check("R5", $sformatf("vec%0d idle", v), int'(bus_idle), int'(VEC[v].e_idle));
    end

    // R1 latency from raw change to start strobe
    drive(1'b1, 1'b0);
    k = 0;
    while (!start_stb && k < 50) begin
      @(negedge clk);
      k++;
    end
    check("R1", "start latency", k, SYNC_STAGES + FILT_LEN + 1);
    wait_cyc(SETTLE);

    // R7: request while clock high is ignored
    tx_pull_low = 1'b1;
    wait_cyc(SETTLE);
    check("R7", "oe held while clock high", int'(sda_oe), 0);

    // R7: hold distance from fall strobe to oe change
    drive(1'b0, 1'b0);
    k = 0;
    while (!scl_fall_stb && k < 50) begin
      @(negedge clk);
      k++;
    end
    k = 0;
    while (!sda_oe && k < 100) begin
      @(negedge clk);
      k++;
    end
    check("R7", "fall strobe to oe cycles", k, HOLD_LEN);

    // R7: within open window the request passes in one cycle
    tx_pull_low = 1'b0;
    @(negedge clk);
    check("R7", "oe follows in open window", int'(sda_oe), 0);

    // R7: clock high again, request ignored
    drive(1'b1, 1'b0);
    wait_cyc(SETTLE);
    tx_pull_low = 1'b1;
    wait_cyc(30);
    check("R7", "oe ignores request at clock high", int'(sda_oe), 0);
    tx_pull_low = 1'b0;

    // R8: reset while a transfer is open
    check("R5", "busy before reset", int'(bus_idle), 0);
    rst = 1'b1;
    drive(1'b1, 1'b1);
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "idle right after reset", int'(bus_idle), 1);
    check("R8", "oe right after reset", int'(sda_oe), 0);
    wait_cyc(SETTLE);

    finish_run();
  end

endmodule